// File: doc/BRIEF.md
# SMBus Host Command Sequencer with I2C Framing Mode

This block sits on the host side of a two-wire serial bus. When it receives a start strobe, it captures the programmed command: a slave address, a command code, two data registers, a byte count, a command type and a mode flag. It then expands that command into an ordered series of bus events. The events are start, repeated start, stop, byte transmit with a slave acknowledge, and byte receive, where the host answers each byte with an ack or a nack. Each event is handed to a byte-level bus engine through a request/done handshake. That engine handles the bit timing on the wires.

The I2C mode flag changes the framing of two commands. Process call drops its command-code byte, and block write drops its count byte. A combined write-then-read block command is always available, whatever the mode flag says. It writes the command code and both data registers, issues a repeated start, and then reads a programmed number of bytes. Block payload bytes are not buffered. The sequencer exchanges them with the host one byte at a time.

A missing slave acknowledge aborts the command with a stop and raises a device-error flag. A malformed request is refused before any bus activity takes place.

Top module: `smb_cmd_seq`

## Requirements
- R1: After reset, busy, done, dev_err, cmd_err, eng_req and hb_req are all 0.
- R2: Command type 3 (combined block read) issues these events in order: start, transmit {slv_addr[7:1],0}, transmit cmd_code, transmit data0, transmit data1, repeated start, transmit {slv_addr[7:1],1}, the receives, and stop. Start, repeated start and stop each count as one serial bit, and every byte with its acknowledge counts as nine. On that count, the repeated start falls on bit 38 and the first received byte begins at bit 48.
- R3: Every received byte except the last is requested with the receive-and-ack operation. The last one is requested with receive-and-nack and is followed directly by stop. In command type 3 the number of received bytes equals byte_cnt, so a count of 1 nacks the first byte. A process call receives exactly two bytes.
- R4: A go is rejected in two cases: command type 3 with slv_addr[0]=1, or a block command (type 2 or 3) with byte_cnt=0. A rejected go sets cmd_err=1 and pulses done. It issues no bus request, and busy stays 0.
- R5: Command type 1 (process call) issues start, address+write, cmd_code, data0, data1, repeated start, address+read, two receives and stop. When i2c_mode=1, the cmd_code byte is left out.
- R6: Command type 2 (block write) issues start, address+write, cmd_code, a count byte equal to byte_cnt, byte_cnt payload bytes and stop. When i2c_mode=1, the count byte is left out.
- R7: For each block-write payload byte, the block raises hb_req and waits for hb_rdy. It then transmits the hb_wdata value captured with hb_rdy. hb_req and eng_req are never high together. Each received byte appears once on hb_rdata with a one-cycle hb_rvalid, in arrival order.
- R8: The event list of command type 3 is identical for i2c_mode=0 and i2c_mode=1.
- R9: If eng_ack=0 when a transmit completes, the next bus event is stop, with no further bytes. dev_err becomes 1 and stays set until the next go. done pulses when the stop completes.
- R10: busy rises in the cycle after an accepted go. It falls in the same cycle that done pulses, which is when the stop completes. done is high for exactly one cycle per command.
- R11: Command type 0 (byte write) issues start, address+write, cmd_code, data0 and stop.
- R12: eng_req stays high with eng_op and eng_wdata stable until a one-cycle eng_done arrives. The eng_op codes are: start 0, repeated start 1, stop 2, transmit 3, receive with ack 4, receive with nack 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe for the programmed command |
| cmd_type | input | 2 | 0 byte write, 1 process call, 2 block write, 3 combined block read |
| i2c_mode | input | 1 | Selects the I2C framing variants |
| slv_addr | input | 8 | [7:1] slave address, [0] direction bit |
| cmd_code | input | 8 | Command code byte |
| data0 | input | 8 | First data register |
| data1 | input | 8 | Second data register |
| byte_cnt | input | CNT_W | Block byte count |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| dev_err | output | 1 | A slave failed to acknowledge |
| cmd_err | output | 1 | Last go was rejected |
| eng_req | output | 1 | Bus engine request |
| eng_op | output | 3 | Bus event code |
| eng_wdata | output | 8 | Byte to transmit |
| eng_done | input | 1 | Bus engine completion pulse |
| eng_ack | input | 1 | Slave acknowledge of a transmitted byte |
| eng_rdata | input | 8 | Received byte |
| hb_req | output | 1 | Request for the next payload byte from the host |
| hb_rdy | input | 1 | Host supplies a payload byte |
| hb_wdata | input | 8 | Payload byte from the host |
| hb_rdata | output | 8 | Received byte to the host |
| hb_rvalid | output | 1 | hb_rdata valid for one cycle |

## Verification
The bench targets the mode-dependent framing: process call and block write are each run in both modes. A sequencer that dropped the wrong byte would show up as an event list one entry short in the wrong place. For the combined read, the bench places the repeated start and the first receive on exact serial bit positions. It uses a count of one, so a sequencer that always acks the first byte, or that leaves out the nack before stop, is caught. A slave nack injected on the command byte must cut the list short at a stop, and a design that carried on transmitting would fail that check. Both rejection causes must produce a done pulse with no bus traffic at all.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RSTART  = 3'd1,
    OP_STOP    = 3'd2,
    OP_TX      = 3'd3,
    OP_RX_ACK  = 3'd4,
    OP_RX_NACK = 3'd5
  } bus_op_e;

  typedef enum logic [1:0] {
    CMD_BYTE_WR   = 2'd0,
    CMD_PROC_CALL = 2'd1,
    CMD_BLK_WR    = 2'd2,
    CMD_COMB_RD   = 2'd3
  } cmd_e;

  typedef enum logic [3:0] {
    PH_START, PH_ADDR_W, PH_CODE, PH_D0, PH_D1, PH_CNT,
    PH_BLKW, PH_RSTART, PH_ADDR_R, PH_RX, PH_STOP
  } phase_e;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_BUS} seq_st_e;

endpackage

// File: rtl/smb_seq_phase_next.sv
module smb_seq_phase_next
  import smb_seq_pkg::*;
(
  input  phase_e cur,
  input  cmd_e   cmd,
  input  logic   i2c,
  output phase_e nxt
);
  always_comb begin
    nxt = PH_STOP;
    case (cur)
      PH_START:  nxt = PH_ADDR_W;
      PH_ADDR_W: nxt = (cmd == CMD_PROC_CALL && i2c) ? PH_D0 : PH_CODE;
      PH_CODE: begin
        if (cmd == CMD_BLK_WR) nxt = i2c ? PH_BLKW : PH_CNT;
        else                   nxt = PH_D0;
      end
      PH_D0:     nxt = (cmd == CMD_BYTE_WR) ? PH_STOP : PH_D1;
      PH_D1:     nxt = PH_RSTART;
      PH_CNT:    nxt = PH_BLKW;
      PH_BLKW:   nxt = PH_STOP;
      PH_RSTART: nxt = PH_ADDR_R;
      PH_ADDR_R: nxt = PH_RX;
      PH_RX:     nxt = PH_STOP;
      default:   nxt = PH_STOP;
    endcase
  end
endmodule

// File: rtl/smb_seq_step_map.sv
module smb_seq_step_map
  import smb_seq_pkg::*;
#(
  parameter int CNT_W = 8
)(
  input  phase_e              ph,
  input  logic [BYTE_W-2:0]   addr7,
  input  logic [BYTE_W-1:0]   code,
  input  logic [BYTE_W-1:0]   d0,
  input  logic [BYTE_W-1:0]   d1,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [BYTE_W-1:0]   blk_byte,
  input  logic                last,
  output bus_op_e             op,
  output logic [BYTE_W-1:0]   data
);
  always_comb begin
    op   = OP_TX;
    data = '0;
    case (ph)
      PH_START:  op = OP_START;
      PH_RSTART: op = OP_RSTART;
      PH_STOP:   op = OP_STOP;
      PH_ADDR_W: data = {addr7, 1'b0};
      PH_ADDR_R: data = {addr7, 1'b1};
      PH_CODE:   data = code;
      PH_D0:     data = d0;
      PH_D1:     data = d1;
      PH_CNT:    data = BYTE_W'(cnt);
      PH_BLKW:   data = blk_byte;
      PH_RX:     op = last ? OP_RX_NACK : OP_RX_ACK;
      default:   op = OP_STOP;
    endcase
  end
endmodule

// File: rtl/smb_seq_byte_ctr.sv
module smb_seq_byte_ctr #(
  parameter int CNT_W = 8
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt
);
  always_comb begin
    if (load)     cnt_nxt = load_val;
    else if (dec) cnt_nxt = cnt - CNT_W'(1);
    else          cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

  // A byte is never counted past the programmed total.
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> (cnt != '0));
endmodule

// File: rtl/smb_cmd_seq.sv
module smb_cmd_seq
  import smb_seq_pkg::*;
#(
  parameter int CNT_W = 8
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [1:0]       cmd_type,
  input  logic             i2c_mode,
  input  logic [7:0]       slv_addr,
  input  logic [7:0]       cmd_code,
  input  logic [7:0]       data0,
  input  logic [7:0]       data1,
  input  logic [CNT_W-1:0] byte_cnt,
  output logic             busy,
  output logic             done,
  output logic             dev_err,
  output logic             cmd_err,
  output logic             eng_req,
  output logic [2:0]       eng_op,
  output logic [7:0]       eng_wdata,
  input  logic             eng_done,
  input  logic             eng_ack,
  input  logic [7:0]       eng_rdata,
  output logic             hb_req,
  input  logic             hb_rdy,
  input  logic [7:0]       hb_wdata,
  output logic [7:0]       hb_rdata,
  output logic             hb_rvalid
);
  localparam logic [CNT_W-1:0] PROC_RX_N = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  seq_st_e            st;
  phase_e             ph, nxt_ph, launch_ph, map_ph;
  cmd_e               cur_cmd, in_cmd;
  logic               cur_i2c;
  logic [6:0]         r_addr7;
  logic [7:0]         r_code, r_d0, r_d1;
  logic [CNT_W-1:0]   r_cnt;
  logic [CNT_W-1:0]   rem, rem_nxt, load_val;
  logic               reject, accept, step_done, tx_nak, multi;
  logic               launch_en, ctr_dec;
  bus_op_e            map_op;
  logic [7:0]         map_data;

  // ---- request qualification --------------------------------------------
  always_comb begin
    in_cmd   = cmd_e'(cmd_type);
    reject   = (in_cmd == CMD_COMB_RD && slv_addr[0]) ||
               ((in_cmd == CMD_BLK_WR || in_cmd == CMD_COMB_RD) && byte_cnt == '0);
    accept   = go && (st == S_IDLE) && !reject;
    load_val = (in_cmd == CMD_PROC_CALL) ? PROC_RX_N : byte_cnt;
  end

  // ---- step control -------------------------------------------------------
  always_comb begin
    step_done = (st == S_BUS) && eng_done;
    tx_nak    = step_done && (eng_op == OP_TX) && !eng_ack;
    multi     = (ph == PH_BLKW) || (ph == PH_RX);
    ctr_dec   = step_done && multi;
    if (accept)                 launch_ph = PH_START;
    else if (tx_nak)            launch_ph = PH_STOP;
    else if (multi && rem > ONE) launch_ph = ph;
    else                        launch_ph = nxt_ph;
    launch_en = accept || (step_done && ph != PH_STOP);
    map_ph    = (st == S_FETCH) ? PH_BLKW : launch_ph;
  end

  smb_seq_phase_next u_next (
    .cur (ph),
    .cmd (cur_cmd),
    .i2c (cur_i2c),
    .nxt (nxt_ph)
  );

  smb_seq_byte_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (load_val),
    .dec      (ctr_dec),
    .cnt      (rem),
    .cnt_nxt  (rem_nxt)
  );

  smb_seq_step_map #(.CNT_W(CNT_W)) u_map (
    .ph       (map_ph),
    .addr7    (r_addr7),
    .code     (r_code),
    .d0       (r_d0),
    .d1       (r_d1),
    .cnt      (r_cnt),
    .blk_byte (hb_wdata),
    .last     (rem_nxt == ONE),
    .op       (map_op),
    .data     (map_data)
  );

  // ---- sequencing registers ----------------------------------------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ph        <= PH_START;
      cur_cmd   <= CMD_BYTE_WR;
      cur_i2c   <= 1'b0;
      r_addr7   <= '0;
      r_code    <= '0;
      r_d0      <= '0;
      r_d1      <= '0;
      r_cnt     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      dev_err   <= 1'b0;
      cmd_err   <= 1'b0;
      eng_req   <= 1'b0;
      eng_op    <= OP_START;
      eng_wdata <= '0;
      hb_req    <= 1'b0;
      hb_rdata  <= '0;
      hb_rvalid <= 1'b0;
    end else begin
      done      <= 1'b0;
      hb_rvalid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go) begin
            cmd_err <= reject;
            dev_err <= 1'b0;
            if (reject) begin
              done <= 1'b1;
            end else begin
              busy    <= 1'b1;
              cur_cmd <= in_cmd;
              cur_i2c <= i2c_mode;
              r_addr7 <= slv_addr[7:1];
              r_code  <= cmd_code;
              r_d0    <= data0;
              r_d1    <= data1;
              r_cnt   <= byte_cnt;
            end
          end
        end
        S_FETCH: begin
          if (hb_rdy) begin
            hb_req    <= 1'b0;
            eng_req   <= 1'b1;
            eng_op    <= map_op;
            eng_wdata <= map_data;
            st        <= S_BUS;
          end
        end
        S_BUS: begin
          if (eng_done) begin
            eng_req <= 1'b0;
            if (tx_nak) dev_err <= 1'b1;
            if (ph == PH_RX) begin
              hb_rvalid <= 1'b1;
              hb_rdata  <= eng_rdata;
            end
            if (ph == PH_STOP) begin
              st   <= S_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase

      if (launch_en) begin
        ph <= launch_ph;
        if (launch_ph == PH_BLKW) begin
          st      <= S_FETCH;
          hb_req  <= 1'b1;
          eng_req <= 1'b0;
        end else begin
          st        <= S_BUS;
          eng_req   <= 1'b1;
          eng_op    <= map_op;
          eng_wdata <= map_data;
        end
      end
    end
  end

  // ---- assertions -----------------------------------------------------------
  assert_req_stable_R12: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_wdata)));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_one_owner_R7: assert property (@(posedge clk) disable iff (rst)
    !(hb_req && eng_req));

  assert_nak_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_done && eng_op == OP_TX && !eng_ack) |=>
      (eng_req && eng_op == OP_STOP && dev_err));

  assert_nack_then_stop_R3: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_done && eng_op == OP_RX_NACK) |=> (eng_req && eng_op == OP_STOP));

  assert_reject_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> (!busy && !eng_req && !hb_req));
endmodule

// File: tb/smb_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module smb_cmd_seq_tb_top;
  localparam int OP_START = 0, OP_RS = 1, OP_STOP = 2, OP_TX = 3, OP_RXA = 4, OP_RXN = 5;

  logic clk = 0, rst = 1, go = 0, i2c_mode = 0;
  logic [1:0] cmd_type = 0;
  logic [7:0] slv_addr = 0, cmd_code = 0, data0 = 0, data1 = 0, byte_cnt = 0;
  logic busy, done, dev_err, cmd_err, eng_req, hb_req, hb_rvalid;
  logic [2:0] eng_op;
  logic [7:0] eng_wdata, hb_rdata;
  logic eng_done = 0, eng_ack = 1, hb_rdy = 0;
  logic [7:0] eng_rdata = 0, hb_wdata = 0;

  always #2 clk = ~clk;

  smb_cmd_seq #(.CNT_W(8)) dut_i (
    .clk(clk), .rst(rst), .go(go), .cmd_type(cmd_type), .i2c_mode(i2c_mode),
    .slv_addr(slv_addr), .cmd_code(cmd_code), .data0(data0), .data1(data1),
    .byte_cnt(byte_cnt), .busy(busy), .done(done), .dev_err(dev_err),
    .cmd_err(cmd_err), .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
    .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
    .hb_req(hb_req), .hb_rdy(hb_rdy), .hb_wdata(hb_wdata),
    .hb_rdata(hb_rdata), .hb_rvalid(hb_rvalid)
  );

  int n_chk = 0, n_bad = 0;
  int ev_op [0:63], ev_dat [0:63], ev_n = 0;
  int exp_op[0:63], exp_dat[0:63], exp_n = 0;
  int rcv [0:63], rcv_n = 0;
  int wr_n = 0, rx_cnt = 0, nak_at = -1, stab_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Behavioural bus engine / slave: logs each event, checks request stability.
  initial forever begin
    @(negedge clk);
    if (eng_req && !rst) begin
      automatic int op = int'(eng_op);
      automatic int dat = int'(eng_wdata);
      ev_op[ev_n]  = op;
      ev_dat[ev_n] = (op == OP_TX) ? dat : 0;
      repeat (2) begin
        @(negedge clk);
        if (!eng_req || int'(eng_op) != op || int'(eng_wdata) != dat) stab_err++;
      end
      eng_ack   = (ev_n == nak_at) ? 1'b0 : 1'b1;
      eng_rdata = 8'hC0 + 8'(rx_cnt);
      if (op == OP_RXA || op == OP_RXN) rx_cnt++;
      ev_n++;
      eng_done = 1;
      @(negedge clk);
      eng_done = 0;
      eng_ack  = 1;
    end
  end

  // Behavioural host: supplies payload bytes and collects received ones.
  initial forever begin
    @(negedge clk);
    if (hb_rvalid) begin rcv[rcv_n] = int'(hb_rdata); rcv_n++; end
    if (hb_req && !hb_rdy) begin
      hb_wdata = 8'h30 + 8'(wr_n);
      wr_n++;
      hb_rdy = 1;
    end else begin
      hb_rdy = 0;
    end
  end

  task automatic push(input int op, input int dat);
    exp_op[exp_n] = op; exp_dat[exp_n] = dat; exp_n++;
  endtask

  task automatic cmp_log(input string tag);
    chk(ev_n == exp_n, {tag, " event count"}, ev_n, exp_n);
    for (int i = 0; i < exp_n && i < ev_n; i++)
      chk(ev_op[i] == exp_op[i] && ev_dat[i] == exp_dat[i], {tag, " event"},
          ev_op[i] * 256 + ev_dat[i], exp_op[i] * 256 + exp_dat[i]);
  endtask

  task automatic run_cmd(input int cmd, input bit md, input logic [7:0] a,
                         input logic [7:0] c, input logic [7:0] x0, input logic [7:0] x1,
                         input logic [7:0] n, input int nak, input bit acc);
    int t;
    ev_n = 0; rcv_n = 0; wr_n = 0; rx_cnt = 0; nak_at = nak; stab_err = 0; exp_n = 0;
    @(negedge clk);
    cmd_type = 2'(cmd); i2c_mode = md; slv_addr = a; cmd_code = c;
    data0 = x0; data1 = x1; byte_cnt = n; go = 1;
    @(negedge clk);
    go = 0;
    chk(busy == acc, "R10 busy after go", busy, acc);
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done == 1, "R10 done seen", done, 1);
    chk(busy == 0, "R10 busy low at done", busy, 0);
    @(negedge clk);
    chk(done == 0, "R10 done single cycle", done, 0);
    chk(stab_err == 0, "R12 request stable until done", stab_err, 0);
  endtask

  task automatic test_reset();
    chk(busy == 0 && done == 0 && eng_req == 0 && hb_req == 0, "R1 reset outputs",
        {busy, done, eng_req, hb_req}, 0);
    chk(dev_err == 0 && cmd_err == 0, "R1 reset flags", {dev_err, cmd_err}, 0);
  endtask

  task automatic test_byte_wr();
    run_cmd(0, 0, 8'hA0, 8'h11, 8'h22, 8'h33, 8'h0, -1, 1);
    push(OP_START, 0); push(OP_TX, 8'hA0); push(OP_TX, 8'h11); push(OP_TX, 8'h22);
    push(OP_STOP, 0);
    cmp_log("R11 byte write");
    chk(cmd_err == 0 && dev_err == 0, "R11 no error flags", {cmd_err, dev_err}, 0);
  endtask

  task automatic exp_comb_rd(input int n);
    push(OP_START, 0); push(OP_TX, 8'hA4); push(OP_TX, 8'h5C); push(OP_TX, 8'h01);
    push(OP_TX, 8'h02); push(OP_RS, 0); push(OP_TX, 8'hA5);
    for (int k = 0; k < n; k++) push(k == n - 1 ? OP_RXN : OP_RXA, 0);
    push(OP_STOP, 0);
  endtask

  task automatic test_comb_rd(input bit md, input int n);
    int pos, rs_pos, rx_pos;
    run_cmd(3, md, 8'hA4, 8'h5C, 8'h01, 8'h02, 8'(n), -1, 1);
    exp_comb_rd(n);
    cmp_log(md ? "R2 R3 combined read" : "R8 R3 combined read mode 0");
    pos = 1; rs_pos = -1; rx_pos = -1;
    for (int i = 0; i < ev_n; i++) begin
      if (ev_op[i] == OP_RS && rs_pos < 0) rs_pos = pos;
      if ((ev_op[i] == OP_RXA || ev_op[i] == OP_RXN) && rx_pos < 0) rx_pos = pos;
      pos += (ev_op[i] == OP_TX || ev_op[i] == OP_RXA || ev_op[i] == OP_RXN) ? 9 : 1;
    end
    chk(rs_pos == 38, "R2 repeated start bit position", rs_pos, 38);
    chk(rx_pos == 48, "R2 first receive bit position", rx_pos, 48);
    chk(rcv_n == n, "R7 received byte count", rcv_n, n);
    for (int k = 0; k < n && k < rcv_n; k++)
      chk(rcv[k] == 8'hC0 + k, "R7 received byte order", rcv[k], 8'hC0 + k);
  endtask

  task automatic test_proc(input bit md);
    run_cmd(1, md, 8'h6E, 8'h77, 8'h12, 8'h34, 8'h9, -1, 1);
    push(OP_START, 0); push(OP_TX, 8'h6E);
    if (!md) push(OP_TX, 8'h77);
    push(OP_TX, 8'h12); push(OP_TX, 8'h34); push(OP_RS, 0); push(OP_TX, 8'h6F);
    push(OP_RXA, 0); push(OP_RXN, 0); push(OP_STOP, 0);
    cmp_log(md ? "R5 process call i2c" : "R5 process call smbus");
    chk(rcv_n == 2, "R3 process call receives two", rcv_n, 2);
  endtask

  task automatic test_blk_wr(input bit md, input int n);
    run_cmd(2, md, 8'h40, 8'h9A, 8'hEE, 8'hDD, 8'(n), -1, 1);
    push(OP_START, 0); push(OP_TX, 8'h40); push(OP_TX, 8'h9A);
    if (!md) push(OP_TX, n);
    for (int k = 0; k < n; k++) push(OP_TX, 8'h30 + k);
    push(OP_STOP, 0);
    cmp_log(md ? "R6 R7 block write i2c" : "R6 R7 block write smbus");
    chk(wr_n == n, "R7 host handshakes", wr_n, n);
  endtask

  task automatic test_reject();
    run_cmd(3, 1, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h4, -1, 0);
    repeat (4) @(negedge clk);
    chk(cmd_err == 1, "R4 read with direction bit set flagged", cmd_err, 1);
    chk(ev_n == 0, "R4 no bus events on reject", ev_n, 0);
    run_cmd(2, 0, 8'h40, 8'h00, 8'h00, 8'h00, 8'h0, -1, 0);
    repeat (4) @(negedge clk);
    chk(cmd_err == 1, "R4 zero count flagged", cmd_err, 1);
    chk(ev_n == 0 && wr_n == 0, "R4 zero count silent", ev_n + wr_n, 0);
  endtask

  task automatic test_nak();
    run_cmd(3, 1, 8'hA4, 8'h5C, 8'h01, 8'h02, 8'h3, 2, 1);
    push(OP_START, 0); push(OP_TX, 8'hA4); push(OP_TX, 8'h5C); push(OP_STOP, 0);
    cmp_log("R9 nack abort");
    chk(dev_err == 1, "R9 device error set", dev_err, 1);
    chk(cmd_err == 0, "R9 no request error", cmd_err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    test_reset();
    rst = 0;
    @(negedge clk);
    test_reset();
    test_byte_wr();
    test_comb_rd(1, 3);
    test_comb_rd(0, 1);
    test_proc(0);
    test_proc(1);
    test_blk_wr(0, 2);
    test_blk_wr(1, 3);
    test_reject();
    test_nak();
    report();
    $finish;
  end
endmodule